// File: doc/BRIEF.md
# Cyclic Four-Phase Code Sequencer with Step Difference

This block walks through four phases in a fixed ring, one phase per rising clock edge. For each phase it presents a 4-bit code taken from one of two tables. A one-bit select input picks the table. A second 4-bit output gives the step: the current code minus the code that was on the output just before the last edge, wrapped modulo 16. A downstream unit can use it to see how far the code moved, without keeping its own copy of the old value.

The select input does not alter the phase order. It only changes which table is read. The code and the step are combinational in the select, so a change of select shows on both outputs in the same cycle. A register captures the code at every rising edge. After reset that register holds nothing meaningful, so the step output reads zero until the first edge has loaded it.

There is no streaming data path here. All pins are plain control and status pins, with no valid/ready handshake.

Top module: `ring_delta_fsm`

## Requirements
- R1: While `rst` is high (asynchronous, active high), the phase is 0 at once, `code_o` shows the phase-0 entry of the selected table, and `delta_o` is 0.
- R2: With `rst` low, every rising edge of `clk` advances the phase 0→1→2→3→0, whatever `sel_i` is.
- R3: With `sel_i`=1, `code_o` is 0x1, 0x3, 0x5, 0x7 in phases 0, 1, 2, 3.
- R4: With `sel_i`=0, `code_o` is 0xA, 0xB, 0xC, 0xD in phases 0, 1, 2, 3.
- R5: A change of `sel_i` inside a cycle changes `code_o` and `delta_o` in that same cycle, with no clock edge, and leaves the phase unchanged.
- R6: At each rising edge with `rst` low, the history register loads the value `code_o` had just before that edge.
- R7: After the first edge that follows reset, `delta_o` equals `code_o` minus the history register, modulo 16.
- R8: From reset release until the first rising edge, `delta_o` is 0 for either value of `sel_i`.
- R9: Differences that cross zero wrap. For example, 0x1 after 0xD gives 0x4, and 0x3 after 0xA gives 0x9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| sel_i | input | 1 | Table select: 1 picks the odd table, 0 picks the 0xA.. table |
| code_o | output | 4 | Code for the current phase and select |
| delta_o | output | 4 | Current code minus the code before the last edge, modulo 16 |

## Verification
The assertions assume three things about the inputs:
- `rst` is high from time zero through the first rising edge.
- `sel_i` is always a known 0 or 1.
- `sel_i` changes only away from the rising edge, so the value sampled at an edge is the one that was on the pins during the cycle before it.

The table-walk and difference properties therefore compare the present code against sampled past values. They are gated off in the cycle that follows a reset.

The stimulus follows these rules. `sel_i` and `rst` are driven only at falling edges, or a few time units after them. Outputs are sampled one time unit after the input change. Reset is asserted from time zero.

// File: rtl/ring_delta_pkg.sv
package ring_delta_pkg;
  // Default geometry of the sequencer
  localparam int DEF_PHASES  = 4;
  localparam int DEF_CODE_W  = 4;
  // Default table shapes: entry(i) = base + step * i
  localparam int DEF_HI_BASE = 1;
  localparam int DEF_HI_STEP = 2;
  localparam int DEF_LO_BASE = 10;
  localparam int DEF_LO_STEP = 1;

  function automatic int table_entry(input int base, input int step, input int idx);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/rdf_ring_counter.sv
module rdf_ring_counter #(
  parameter int N_PHASES = 4,
  localparam int IDX_W = (N_PHASES > 1) ? $clog2(N_PHASES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] phase_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_PHASES - 1);

  logic [IDX_W-1:0] phase_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                 phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign phase_o = phase_q;

  // R1: phase sits at zero while reset is held
  assert_reset_home_R1: assert property (@(posedge clk) rst |-> phase_q == '0);

  // R2: one step per edge, wrapping after the last phase
  assert_ring_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(phase_q) != LAST) |-> phase_q == IDX_W'($past(phase_q) + 1'b1));
  assert_ring_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(phase_q) == LAST) |-> phase_q == '0);
endmodule

// File: rtl/rdf_code_table.sv
module rdf_code_table #(
  parameter int N_PHASES = 4,
  parameter int CODE_W   = 4,
  parameter int HI_BASE  = 1,
  parameter int HI_STEP  = 2,
  parameter int LO_BASE  = 10,
  parameter int LO_STEP  = 1,
  localparam int IDX_W = (N_PHASES > 1) ? $clog2(N_PHASES) : 1
) (
  input  logic [IDX_W-1:0]  phase_i,
  input  logic              sel_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] hi_rom [N_PHASES];
  logic [CODE_W-1:0] lo_rom [N_PHASES];

  for (genvar g = 0; g < N_PHASES; g++) begin : g_rom
    assign hi_rom[g] = CODE_W'(ring_delta_pkg::table_entry(HI_BASE, HI_STEP, g));
    assign lo_rom[g] = CODE_W'(ring_delta_pkg::table_entry(LO_BASE, LO_STEP, g));
  end

  always_comb begin
    code_o = '0;
    if (int'(phase_i) < N_PHASES) begin
      code_o = sel_i ? hi_rom[phase_i] : lo_rom[phase_i];
    end
  end
endmodule

// File: rtl/rdf_delta_unit.sv
module rdf_delta_unit #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] delta_o
);
  logic [CODE_W-1:0] prev_q;
  logic              hist_q;
  logic [CODE_W-1:0] diff;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prev_q <= '0;
      hist_q <= 1'b0;
    end else begin
      prev_q <= code_i;
      hist_q <= 1'b1;
    end
  end

  assign diff    = code_i - prev_q;
  assign delta_o = hist_q ? diff : '0;

  // R6: the history register holds the code seen at the previous edge
  assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> prev_q == $past(code_i));

  // R8: history is valid one edge after reset is released
  assert_hist_live_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> hist_q);
endmodule

// File: rtl/ring_delta_fsm.sv
module ring_delta_fsm #(
  parameter int N_PHASES = ring_delta_pkg::DEF_PHASES,
  parameter int CODE_W   = ring_delta_pkg::DEF_CODE_W,
  parameter int HI_BASE  = ring_delta_pkg::DEF_HI_BASE,
  parameter int HI_STEP  = ring_delta_pkg::DEF_HI_STEP,
  parameter int LO_BASE  = ring_delta_pkg::DEF_LO_BASE,
  parameter int LO_STEP  = ring_delta_pkg::DEF_LO_STEP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] delta_o
);
  localparam int IDX_W = (N_PHASES > 1) ? $clog2(N_PHASES) : 1;
  localparam logic [CODE_W-1:0] HI_FIRST = CODE_W'(HI_BASE);
  localparam logic [CODE_W-1:0] LO_FIRST = CODE_W'(LO_BASE);
  localparam logic [CODE_W-1:0] HI_LAST  = CODE_W'(HI_BASE + HI_STEP * (N_PHASES - 1));
  localparam logic [CODE_W-1:0] LO_LAST  = CODE_W'(LO_BASE + LO_STEP * (N_PHASES - 1));
  localparam logic [CODE_W-1:0] HI_INC   = CODE_W'(HI_STEP);
  localparam logic [CODE_W-1:0] LO_INC   = CODE_W'(LO_STEP);

  logic [IDX_W-1:0] phase;

  rdf_ring_counter #(.N_PHASES(N_PHASES)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .phase_o (phase)
  );

  rdf_code_table #(
    .N_PHASES (N_PHASES),
    .CODE_W   (CODE_W),
    .HI_BASE  (HI_BASE),
    .HI_STEP  (HI_STEP),
    .LO_BASE  (LO_BASE),
    .LO_STEP  (LO_STEP)
  ) u_table (
    .phase_i (phase),
    .sel_i   (sel_i),
    .code_o  (code_o)
  );

  rdf_delta_unit #(.CODE_W(CODE_W)) u_delta (
    .clk     (clk),
    .rst     (rst),
    .code_i  (code_o),
    .delta_o (delta_o)
  );

  // R1: reset presents the phase-0 entry of the chosen table and a zero step
  assert_reset_out_R1: assert property (@(posedge clk)
    rst |-> (code_o == (sel_i ? HI_FIRST : LO_FIRST)) && (delta_o == '0));

  // R3: odd table walks by its step and wraps to its first entry
  assert_hi_walk_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_i && $past(sel_i) && !$past(rst) && $past(code_o) != HI_LAST)
      |-> code_o == CODE_W'($past(code_o) + HI_INC));
  assert_hi_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_i && $past(sel_i) && !$past(rst) && $past(code_o) == HI_LAST)
      |-> code_o == HI_FIRST);

  // R4: alternate table walks by its step and wraps to its first entry
  assert_lo_walk_R4: assert property (@(posedge clk) disable iff (rst)
    (!sel_i && !$past(sel_i) && !$past(rst) && $past(code_o) != LO_LAST)
      |-> code_o == CODE_W'($past(code_o) + LO_INC));
  assert_lo_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (!sel_i && !$past(sel_i) && !$past(rst) && $past(code_o) == LO_LAST)
      |-> code_o == LO_FIRST);

  // R7: step equals present code minus the code one edge earlier, modulo 2^CODE_W
  assert_step_mod_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> delta_o == CODE_W'(code_o - $past(code_o)));
endmodule

// File: tb/ring_delta_fsm_bench.sv
module ring_delta_fsm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 16;

  // {sel, expected code, expected step}, one entry per cycle after reset release
  localparam logic [8:0] VEC [N_VEC] = '{
    {1'b1, 4'h1, 4'h0},  // phase 0, step still 0 (R8)
    {1'b1, 4'h3, 4'h2},
    {1'b1, 4'h5, 4'h2},
    {1'b1, 4'h7, 4'h2},
    {1'b0, 4'hA, 4'h3},
    {1'b0, 4'hB, 4'h1},
    {1'b0, 4'hC, 4'h1},
    {1'b0, 4'hD, 4'h1},
    {1'b1, 4'h1, 4'h4},  // wrap 1 - D (R9)
    {1'b0, 4'hB, 4'hA},
    {1'b1, 4'h5, 4'hA},  // wrap 5 - B
    {1'b0, 4'hD, 4'h8},
    {1'b0, 4'hA, 4'hD},  // wrap A - D
    {1'b1, 4'h3, 4'h9},  // wrap 3 - A
    {1'b0, 4'hC, 4'h9},
    {1'b1, 4'h7, 4'hB}   // wrap 7 - C
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_i = 1'b1;
  logic [3:0] code_o;
  logic [3:0] delta_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_delta_fsm u_ring_delta_fsm (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (sel_i),
    .code_o  (code_o),
    .delta_o (delta_o)
  );

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [3:0] model_code(input int ph, input logic s);
    return s ? 4'(1 + 2 * ph) : 4'(10 + ph);
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int   ph;
    logic [3:0] prevv;
    bit   hist;
    logic [3:0] ec;

    // R1: reset state with both selects
    #1;
    check("R1 code sel=1", code_o, 4'h1);
    check("R1 delta", delta_o, 4'h0);
    sel_i = 1'b0; #1;
    check("R1 code sel=0", code_o, 4'hA);
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // Vector table: R2 R3 R4 R7 R8 R9
    for (int i = 0; i < N_VEC; i++) begin
      if (i > 0) @(negedge clk);
      sel_i = VEC[i][8];
      #1;
      check("R2/R3/R4 code", code_o, VEC[i][7:4]);
      check("R7/R8/R9 delta", delta_o, VEC[i][3:0]);
    end

    // R5: select flips inside phase 0 with no edge; code before edge was 7
    @(negedge clk);
    sel_i = 1'b1; #1;
    check("R5 code sel=1", code_o, 4'h1);
    check("R5 delta sel=1", delta_o, 4'hA);
    sel_i = 1'b0; #1;
    check("R5 code sel=0", code_o, 4'hA);
    check("R5 delta sel=0", delta_o, 4'h3);

    // R1 R8: asynchronous reset mid-cycle in phase 1
    @(negedge clk);
    #2 rst = 1'b1; #1;
    check("R1 async code", code_o, 4'hA);
    check("R8 async delta", delta_o, 4'h0);
    sel_i = 1'b1; #1;
    check("R1 async code sel=1", code_o, 4'h1);
    @(negedge clk);
    #1;
    check("R1 held through edge", code_o, 4'h1);
    check("R8 held delta", delta_o, 4'h0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check("R6 first capture code", code_o, 4'h3);
    check("R6 first capture delta", delta_o, 4'h2);

    // Reference model with random select: R2 R3 R4 R6 R7
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    ph = 0; hist = 0; prevv = 4'h0;
    for (int c = 0; c < 400; c++) begin
      if (c > 0) @(negedge clk);
      sel_i = 1'($urandom % 2);
      #1;
      ec = model_code(ph, sel_i);
      check("R3/R4 model code", code_o, ec);
      check("R6/R7 model delta", delta_o, hist ? 4'(ec - prevv) : 4'h0);
      prevv = ec;
      ph = (ph + 1) % 4;
      hist = 1;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule